// File: doc/BRIEF.md
# Root Port Error Status Tracker

This block keeps the error-status word of a root port. Three single-cycle event inputs report a received correctable error, a received fatal error and a received nonfatal error. Each error class has two flags. The "first" flag records that at least one error of that class arrived. The "multiple" flag records that a later error of the same class arrived while the first flag was still set, which means the earlier message's details may have been overwritten. Fatal and nonfatal errors share the uncorrectable class.

Software reads the 32-bit status word through a simple register port and clears flags by writing 1 to them. The flags survive a system (warm) reset so that the status is still there after the recovery reset. Only the power-on reset clears them. A summary output is high whenever any flag is set, so a downstream interrupt generator can use it.

Top module: `rp_err_status`

## Requirements
- R1: After power-on reset (`por_n` low at a clock edge), all four flags are 0, `summary_o` is 0 and `rd_data_o` is 0.
- R2: The status word uses these bit positions: bit 0 is correctable-first, bit 1 is correctable-multiple, bit 2 is uncorrectable-first and bit 3 is uncorrectable-multiple. Bits 31:4 always read as 0.
- R3: A `cor_err_i` pulse sets bit 0 at the next clock edge.
- R4: A `fatal_err_i` or `nonfatal_err_i` pulse sets bit 2 at the next clock edge.
- R5: A multiple flag sets only when an error of its class arrives while the matching first flag was already set before that cycle. When the first flag is clear, the errors of one cycle (including a fatal and a nonfatal error together) set only the first flag.
- R6: A write of `wr_data_i` to the status address clears each of bits 3:0 that is written as 1. Bits written as 0 are unchanged. Bits 31:4 of the write data have no effect.
- R7: If a clear and a set condition hit the same flag in the same cycle, the flag ends up 1.
- R8: A low `sys_rst_n` leaves all flags unchanged. It also forces the read-data register to 0.
- R9: The status word sits at byte address 0x130, and bits 1:0 of the address are ignored. A read at any other word returns 0, and a write to any other word changes no flag.
- R10: `summary_o` is 1 exactly when at least one of the four flags is 1.
- R11: `rd_data_o` is a register. When `rd_en_i` is high at a clock edge it loads the addressed word. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears flags |
| sys_rst_n | input | 1 | System reset, active low, synchronous; flags retained |
| cor_err_i | input | 1 | Correctable error received (one-cycle pulse) |
| fatal_err_i | input | 1 | Fatal error received (one-cycle pulse) |
| nonfatal_err_i | input | 1 | Nonfatal error received (one-cycle pulse) |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte address of the access |
| wr_data_i | input | 32 | Write data (1 clears a flag) |
| rd_data_o | output | 32 | Registered read data |
| summary_o | output | 1 | High while any flag is set |

## Verification
The assertions treat the three error inputs as independent events of one cycle each. They assume a write strobe comes with a valid address. They place no limit on how events and writes combine, so the set-over-clear case falls inside their scope. The stimulus drives every input half a cycle away from the active edge and holds each event for exactly one cycle. It combines events with writes on purpose: same-cycle fatal and nonfatal errors, clear together with set, and writes to other addresses. System reset is applied only while the event and write inputs are idle, which is the condition the retention property relies on.

// File: rtl/rp_err_pkg.sv
// Package: shared constants for the root port error status tracker.
// The flag index is class*FLAGS_PER_CLASS + kind, with kind 0 = first and 1 = multiple.
package rp_err_pkg;
    localparam int NUM_CLASS       = 2;
    localparam int FLAGS_PER_CLASS = 2;
    localparam int STAT_W          = NUM_CLASS * FLAGS_PER_CLASS;

    typedef enum logic [0:0] {
        CLS_COR = 1'b0,
        CLS_UNC = 1'b1
    } err_class_e;

    localparam int KIND_FIRST = 0;
    localparam int KIND_MULTI = 1;
endpackage

// File: rtl/rp_err_flag_pair.sv
// Module: first/multiple flag pair for one error class.
// Assumes ev_i is already the OR of every event of this class for this cycle.
// The multiple flag looks at the registered first flag, so when the first flag
// is clear an event sets only the first flag. A set wins over a same-cycle clear.
module rp_err_flag_pair (
    input  logic clk,
    input  logic por_n,
    input  logic ev_i,
    input  logic clr_first_i,
    input  logic clr_multi_i,
    output logic first_o,
    output logic multi_o
);
    logic first_q;
    logic multi_q;

    // Purpose: hold the first flag; only power-on reset clears it.
    always_ff @(posedge clk) begin
        if (!por_n)           first_q <= 1'b0;
        else if (ev_i)        first_q <= 1'b1;
        else if (clr_first_i) first_q <= 1'b0;
    end

    // Purpose: hold the multiple flag; it sets on an event seen while first was already set.
    always_ff @(posedge clk) begin
        if (!por_n)               multi_q <= 1'b0;
        else if (ev_i && first_q) multi_q <= 1'b1;
        else if (clr_multi_i)     multi_q <= 1'b0;
    end

    assign first_o = first_q;
    assign multi_o = multi_q;
endmodule

// File: rtl/rp_err_regif.sv
// Module: register access port for the status word.
// Decodes one word address (low two address bits ignored) and turns writes into
// per-flag clear strobes. The read data is registered and loads on rd_en_i.
// Either reset clears the read register.
module rp_err_regif
    import rp_err_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] REG_OFS = 12'h130
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [STAT_W-1:0] clr_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam logic [ADDR_W-1:0] OFS_W = ADDR_W'(REG_OFS);

    logic              hit;
    logic [DATA_W-1:0] rd_q;
    logic              unused_bits;

    // Purpose: match the word address, ignoring byte-lane bits.
    always_comb hit = (addr_i[ADDR_W-1:2] == OFS_W[ADDR_W-1:2]);

    // Purpose: turn a write of ones at the status word into clear strobes.
    always_comb clr_o = (wr_en_i && hit) ? wr_data_i[STAT_W-1:0] : '0;

    // Purpose: capture read data; clear it on either reset.
    always_ff @(posedge clk) begin
        if (!por_n || !sys_rst_n) rd_q <= '0;
        else if (rd_en_i)         rd_q <= hit ? DATA_W'(stat_i) : '0;
    end

    assign rd_data_o   = rd_q;
    assign unused_bits = ^{wr_data_i[DATA_W-1:STAT_W], addr_i[1:0]};
endmodule

// File: rtl/rp_err_status.sv
// Module: root port error status tracker (top).
// Keeps sticky first/multiple flags for the correctable and uncorrectable classes.
// Fatal and nonfatal events together form the uncorrectable class. Flags survive
// sys_rst_n; only por_n clears them. Assumes the event inputs are one-cycle pulses.
module rp_err_status
    import rp_err_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] REG_OFS = 12'h130
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              cor_err_i,
    input  logic              fatal_err_i,
    input  logic              nonfatal_err_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              summary_o
);
    logic [NUM_CLASS-1:0] cls_ev;
    logic [STAT_W-1:0]    flags_q;
    logic [STAT_W-1:0]    clr;

    // Purpose: merge the raw event pulses into one event per class.
    always_comb begin
        cls_ev          = '0;
        cls_ev[CLS_COR] = cor_err_i;
        cls_ev[CLS_UNC] = fatal_err_i | nonfatal_err_i;
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        rp_err_flag_pair u_pair (
            .clk         (clk),
            .por_n       (por_n),
            .ev_i        (cls_ev[c]),
            .clr_first_i (clr[c*FLAGS_PER_CLASS + KIND_FIRST]),
            .clr_multi_i (clr[c*FLAGS_PER_CLASS + KIND_MULTI]),
            .first_o     (flags_q[c*FLAGS_PER_CLASS + KIND_FIRST]),
            .multi_o     (flags_q[c*FLAGS_PER_CLASS + KIND_MULTI])
        );
    end

    rp_err_regif #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .REG_OFS (REG_OFS)
    ) u_regif (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .rd_en_i   (rd_en_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .stat_i    (flags_q),
        .clr_o     (clr),
        .rd_data_o (rd_data_o)
    );

    // Purpose: summary flag for the interrupt generator.
    always_comb summary_o = |flags_q;
endmodule

// File: rtl/rp_err_status_chk.sv
// Checker: temporal properties of the error status tracker, attached by bind.
// Assumes the event inputs are one-cycle pulses and that addr_i is valid with wr_en_i.
module rp_err_status_chk #(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] REG_OFS = 12'h130
) (
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst_n,
    input logic              cor_err_i,
    input logic              fatal_err_i,
    input logic              nonfatal_err_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [3:0]        flags_q,
    input logic              summary_o
);
    localparam logic [ADDR_W-1:0] OFS_W = ADDR_W'(REG_OFS);
    logic wr_hit;
    assign wr_hit = wr_en_i && (addr_i[ADDR_W-1:2] == OFS_W[ADDR_W-1:2]);

    assert_cor_first_R3: assert property (@(posedge clk) disable iff (!por_n)
        cor_err_i |=> flags_q[0]);

    assert_unc_first_R4: assert property (@(posedge clk) disable iff (!por_n)
        (fatal_err_i || nonfatal_err_i) |=> flags_q[2]);

    assert_cor_multi_cause_R5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flags_q[1]) |-> ($past(flags_q[0]) && $past(cor_err_i)));

    assert_unc_multi_cause_R5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flags_q[3]) |-> ($past(flags_q[2]) && $past(fatal_err_i || nonfatal_err_i)));

    assert_w1c_first_R6: assert property (@(posedge clk) disable iff (!por_n)
        (wr_hit && wr_data_i[0] && !cor_err_i) |=> !flags_q[0]);

    assert_sysrst_keep_R8: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && !cor_err_i && !fatal_err_i && !nonfatal_err_i && !wr_en_i)
        |=> (flags_q == $past(flags_q)));

    assert_summary_event_R10: assert property (@(posedge clk) disable iff (!por_n)
        (cor_err_i || fatal_err_i || nonfatal_err_i) |=> summary_o);
endmodule

bind rp_err_status rp_err_status_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .REG_OFS (REG_OFS)
) u_chk (
    .clk            (clk),
    .por_n          (por_n),
    .sys_rst_n      (sys_rst_n),
    .cor_err_i      (cor_err_i),
    .fatal_err_i    (fatal_err_i),
    .nonfatal_err_i (nonfatal_err_i),
    .wr_en_i        (wr_en_i),
    .addr_i         (addr_i),
    .wr_data_i      (wr_data_i),
    .flags_q        (flags_q),
    .summary_o      (summary_o)
);

// File: tb/rp_err_status_tb.sv
module rp_err_status_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        cor_err_i = 1'b0;
    logic        fatal_err_i = 1'b0;
    logic        nonfatal_err_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [11:0] addr_i = 12'h0;
    logic [31:0] wr_data_i = 32'h0;
    logic [31:0] rd_data_o;
    logic        summary_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    rp_err_status u_dut (
        .clk            (clk),
        .por_n          (por_n),
        .sys_rst_n      (sys_rst_n),
        .cor_err_i      (cor_err_i),
        .fatal_err_i    (fatal_err_i),
        .nonfatal_err_i (nonfatal_err_i),
        .rd_en_i        (rd_en_i),
        .wr_en_i        (wr_en_i),
        .addr_i         (addr_i),
        .wr_data_i      (wr_data_i),
        .rd_data_o      (rd_data_o),
        .summary_o      (summary_o)
    );

    // Vector layout: {cor, fatal, nonfatal, wr, wdata[3:0], expected flags[3:0]}
    localparam logic [11:0] VEC [12] = '{
        12'b1000_0000_0001,  // R3 first correctable
        12'b1000_0000_0011,  // R5 second correctable -> multiple
        12'b0100_0000_0111,  // R4 fatal -> first uncorrectable
        12'b0010_0000_1111,  // R5 nonfatal -> multiple uncorrectable
        12'b0001_0000_1111,  // R6 write of zeros has no effect
        12'b0001_0011_1100,  // R6 clear correctable pair
        12'b0001_1100_0000,  // R6 clear uncorrectable pair
        12'b0110_0000_0100,  // R5 fatal+nonfatal same cycle -> first only
        12'b1001_0100_0001,  // R6 clear unc first while cor sets
        12'b1001_0001_0011,  // R7 set wins over clear
        12'b0001_1111_0000,  // R6 clear all
        12'b1100_0000_0101   // R3/R4 both classes at once
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en_i = 1'b1;
        addr_i  = a;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rd_data_o;
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i   = 1'b1;
        addr_i    = a;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i   = 1'b0;
        wr_data_i = 32'h0;
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        sys_rst_n = 1'b1;
        @(negedge clk);
        check("R1 summary after reset", {31'b0, summary_o}, 32'h0);
        check("R1 rd_data after reset", rd_data_o, 32'h0);
        do_read(12'h130, d);
        check("R1 flags after reset", d, 32'h0);

        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            cor_err_i      = VEC[i][11];
            fatal_err_i    = VEC[i][10];
            nonfatal_err_i = VEC[i][9];
            wr_en_i        = VEC[i][8];
            addr_i         = 12'h130;
            wr_data_i      = {28'h0, VEC[i][7:4]};
            @(negedge clk);
            cor_err_i = 1'b0; fatal_err_i = 1'b0; nonfatal_err_i = 1'b0;
            wr_en_i = 1'b0; wr_data_i = 32'h0;
            do_read(12'h130, d);
            check($sformatf("R2/R5/R6 vector %0d flags", i), d, {28'h0, VEC[i][3:0]});
            check($sformatf("R10 vector %0d summary", i), {31'b0, summary_o},
                  {31'b0, (VEC[i][3:0] != 4'h0)});
        end

        // Flags are now 0101
        do_read(12'h134, d);
        check("R9 read of other word", d, 32'h0);
        do_read(12'h133, d);
        check("R9 low address bits ignored", d, 32'h5);
        do_write(12'h200, 32'hF);
        do_read(12'h130, d);
        check("R9 write elsewhere ignored", d, 32'h5);
        do_write(12'h130, 32'hFFFF_FFF0);
        do_read(12'h130, d);
        check("R6 upper write bits ignored", d, 32'h5);
        check("R2 upper read bits zero", {4'h0, d[31:4]}, 32'h0);

        // R11: read register holds without a read strobe
        @(negedge clk);
        cor_err_i = 1'b1;
        @(negedge clk);
        cor_err_i = 1'b0;
        @(negedge clk);
        check("R11 read data held", rd_data_o, 32'h5);
        do_read(12'h130, d);
        check("R11 new read", d, 32'h7);

        // R8: system reset keeps flags, clears read register
        @(negedge clk);
        sys_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 rd_data cleared by sys reset", rd_data_o, 32'h0);
        check("R8 summary kept in sys reset", {31'b0, summary_o}, 32'h1);
        sys_rst_n = 1'b1;
        do_read(12'h130, d);
        check("R8 flags kept after sys reset", d, 32'h7);

        // R1: power-on reset clears flags
        @(negedge clk);
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check("R1 summary after por", {31'b0, summary_o}, 32'h0);
        do_read(12'h130, d);
        check("R1 flags after por", d, 32'h0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule